// File: doc/BRIEF.md
# Sparsified Hit-Matrix Readout Controller

This block sits at the edge of a binary hit matrix of 32 rows by 128 columns. The matrix is divided into square tiles of 4x4 pixels, which gives 8 tile rows by 32 tile columns. Each tile has two dedicated wires to the controller. One is an input flag that says the tile holds at least one hit. The other is an output that freezes the tile so that it takes no new hits while it waits to be read. The controller also drives one enable line per pixel column, and it reads back that column's 32 hit bits over row lines that every column shares.

The readout is driven by the data. While no tile flag is raised, the controller does nothing. When flags appear, it freezes every flagged tile at once and stores the current timestamp for each of them. It then walks the frozen tile columns from left to right. In each tile column it enables the four pixel columns one after another. From each column it emits one 20-bit word per hit pixel onto a valid/ready stream. Each word carries the pixel's column, its row and the timestamp stored for its tile. When all four pixel columns of a tile column have been read, the freezes of that tile column are released.

Back-pressure rules on the stream are as follows. Once `out_valid` is high, it stays high and `out_data` does not change until a cycle in which `out_ready` is also high. That cycle transfers exactly one word. While `out_ready` is low, the scan waits, and no word is dropped or repeated.

Top module: `pxr_readout`

## Requirements
- R1: While reset is held and directly after it, `mp_freeze`, `col_en` and `out_valid` are all zero, and the timestamp counter is zero.
- R2: While no tile is frozen, no column enable is asserted and `out_valid` is low. With all flags low, this condition holds indefinitely.
- R3: The controller may be idle when a clock edge samples one or more tile flags high. At that edge it raises the freeze bit of every flagged tile. Bit index = tile_row*32 + tile_col, where tile_row = row/4 and tile_col = col/4. A freeze bit stays high until all four pixel columns of its tile column have been read, and then it drops. Every word on the bus belongs to a tile that is frozen at the time.
- R4: At most one bit of `col_en` is high at any time. A column is enabled only when its tile column contains a frozen tile. The controller ignores row bits that come from tiles which are not frozen.
- R5: Within a pass, words come out in ascending column order. Within one column, they come out in ascending row order.
- R6: The word layout is `out_data[19:13]` = column, `out_data[12:8]` = row and `out_data[7:0]` = timestamp.
- R7: The 8-bit timestamp counter advances by one on each clock edge at which `ts_tick` is high. It wraps from 255 to 0. A word carries the counter value sampled at the edge that froze its tile.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable. Each hit pixel produces exactly one word, with none lost and none duplicated.
- R9: A tile flag may rise while a pass is running, on a tile that is not frozen. That tile is not read in the current pass. It is frozen in the next pass, with the timestamp of that moment.
- R10: With every one of the 4096 pixels hit, all 4096 words come out in order, under back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ts_tick | input | 1 | Advances the timestamp counter by one |
| mp_hit | input | 256 | Hit flag per tile, index tile_row*32+tile_col |
| mp_freeze | output | 256 | Freeze line per tile, same indexing |
| col_en | output | 128 | One-hot pixel column enable |
| row_data | input | 32 | Hit bits of the enabled column, bit = row |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Sink accepts the word |
| out_data | output | 20 | {column, row, timestamp} |

## Verification
The following patterns are used:

- A single pixel and the four corner pixels separate the column field from the row field, and they expose any off-by-one at the matrix edges.
- A full-occupancy matrix under random stalls checks that every tile freezes at once and that the long ordered stream survives back-pressure.
- Random sparse and dense fills at several stall rates test the ordering and the exactly-once delivery.
- A run after more than 256 ticks checks that the timestamp wraps.
- In the late-hit pattern, a new hit lands in a tile that shares a tile column with a tile already frozen, after the pass has begun. The pattern tells whether row masking holds the new hit back for a second pass with a new timestamp.

// File: rtl/pxr_pkg.sv
package pxr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_SEL,
    ST_EMIT
  } rd_state_e;
endpackage

// File: rtl/pxr_first_set.sv
// Lowest-index set bit finder.
module pxr_first_set #(
  parameter int W = 32,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/pxr_ts_bank.sv
// Free-running timestamp counter plus one stored stamp per tile.
module pxr_ts_bank #(
  parameter int NMP  = 256,
  parameter int TS_W = 8,
  localparam int IW  = $clog2(NMP)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            cap_en,
  input  logic [NMP-1:0]  cap_mask,
  input  logic [IW-1:0]   rd_idx,
  output logic [TS_W-1:0] rd_ts
);
  logic [TS_W-1:0] ts_q;
  logic [TS_W-1:0] stamp [NMP];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts_q <= '0;
    else if (tick) ts_q <= ts_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NMP; i++) stamp[i] <= '0;
    end else if (cap_en) begin
      for (int i = 0; i < NMP; i++) begin
        if (cap_mask[i]) stamp[i] <= ts_q;
      end
    end
  end

  assign rd_ts = stamp[rd_idx];
endmodule

// File: rtl/pxr_readout.sv
module pxr_readout
  import pxr_pkg::*;
#(
  parameter int ROWS   = 32,
  parameter int COLS   = 128,
  parameter int MP_DIM = 4,
  parameter int TS_W   = 8,
  localparam int MP_ROWS = ROWS / MP_DIM,
  localparam int MP_COLS = COLS / MP_DIM,
  localparam int NMP     = MP_ROWS * MP_COLS,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int WORD_W  = COL_W + ROW_W + TS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ts_tick,
  input  logic [NMP-1:0]    mp_hit,
  output logic [NMP-1:0]    mp_freeze,
  output logic [COLS-1:0]   col_en,
  input  logic [ROWS-1:0]   row_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  localparam int MPC_W = $clog2(MP_COLS);
  localparam int MPR_W = $clog2(MP_ROWS);
  localparam int SUB_W = $clog2(MP_DIM);
  localparam int MPI_W = MPR_W + MPC_W;

  rd_state_e         st;
  logic [NMP-1:0]    frz;
  logic [MPC_W-1:0]  mpc;
  logic [SUB_W-1:0]  sub;
  logic [ROWS-1:0]   pend;

  logic [MP_COLS-1:0] col_any;
  logic [ROWS-1:0]    row_keep;
  logic               col_found, row_found;
  logic [MPC_W-1:0]   col_pick;
  logic [ROW_W-1:0]   row_pick;
  logic [COL_W-1:0]   cur_col;
  logic [TS_W-1:0]    word_ts;
  logic               hit_any;

  assign hit_any = |mp_hit;
  assign cur_col = {mpc, sub};

  // Tile columns still holding a frozen tile.
  always_comb begin
    col_any = '0;
    for (int mr = 0; mr < MP_ROWS; mr++) begin
      for (int mc = 0; mc < MP_COLS; mc++) begin
        col_any[mc] = col_any[mc] | frz[mr*MP_COLS + mc];
      end
    end
  end

  // Rows whose tile in the current tile column was frozen this pass.
  always_comb begin
    for (int r = 0; r < ROWS; r++) begin
      row_keep[r] = frz[(r / MP_DIM) * MP_COLS + int'(mpc)];
    end
  end

  pxr_first_set #(.W(MP_COLS)) u_colpick (
    .vec(col_any), .found(col_found), .idx(col_pick)
  );

  pxr_first_set #(.W(ROWS)) u_rowpick (
    .vec(pend), .found(row_found), .idx(row_pick)
  );

  pxr_ts_bank #(.NMP(NMP), .TS_W(TS_W)) u_ts (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (ts_tick),
    .cap_en  (st == ST_IDLE && hit_any),
    .cap_mask(mp_hit),
    .rd_idx  (MPI_W'({row_pick[ROW_W-1 -: MPR_W], mpc})),
    .rd_ts   (word_ts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      frz  <= '0;
      mpc  <= '0;
      sub  <= '0;
      pend <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (hit_any) begin
            frz <= mp_hit;
            st  <= ST_SEEK;
          end
        end
        ST_SEEK: begin
          if (col_found) begin
            mpc <= col_pick;
            sub <= '0;
            st  <= ST_SEL;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_SEL: begin
          pend <= row_data & row_keep;
          st   <= ST_EMIT;
        end
        ST_EMIT: begin
          if (row_found) begin
            if (out_ready) pend[row_pick] <= 1'b0;
          end else if (sub == SUB_W'(MP_DIM - 1)) begin
            for (int mr = 0; mr < MP_ROWS; mr++) begin
              frz[mr*MP_COLS + int'(mpc)] <= 1'b0;
            end
            st <= ST_SEEK;
          end else begin
            sub <= sub + 1'b1;
            st  <= ST_SEL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    col_en = '0;
    if (st == ST_SEL) col_en[cur_col] = 1'b1;
  end

  assign mp_freeze = frz;
  assign out_valid = (st == ST_EMIT) && row_found;
  assign out_data  = {cur_col, row_pick, word_ts};
endmodule

// File: rtl/pxr_readout_chk.sv
module pxr_readout_chk #(
  parameter int ROWS   = 32,
  parameter int COLS   = 128,
  parameter int MP_DIM = 4,
  parameter int TS_W   = 8,
  localparam int MP_ROWS = ROWS / MP_DIM,
  localparam int MP_COLS = COLS / MP_DIM,
  localparam int NMP     = MP_ROWS * MP_COLS,
  localparam int ROW_W   = $clog2(ROWS),
  localparam int COL_W   = $clog2(COLS),
  localparam int WORD_W  = COL_W + ROW_W + TS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NMP-1:0]    mp_freeze,
  input logic [COLS-1:0]   col_en,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data
);
  logic [MP_COLS-1:0] frz_col;
  int                 word_tile;

  always_comb begin
    frz_col = '0;
    for (int mr = 0; mr < MP_ROWS; mr++) begin
      for (int mc = 0; mc < MP_COLS; mc++) begin
        frz_col[mc] = frz_col[mc] | mp_freeze[mr*MP_COLS + mc];
      end
    end
    word_tile = (int'(out_data[TS_W +: ROW_W]) / MP_DIM) * MP_COLS
              + int'(out_data[TS_W + ROW_W +: COL_W]) / MP_DIM;
  end

  AST_COL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_en)) else $error("column enable not one-hot"); // R4

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)) else $error("word dropped or changed under stall"); // R8

  AST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mp_freeze == '0) |-> (col_en == '0 && !out_valid)) else $error("activity with no frozen tile"); // R2

  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mp_freeze[word_tile]) else $error("word from a tile that is not frozen"); // R3

  for (genvar c = 0; c < COLS; c++) begin : g_col
    AST_COL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      col_en[c] |-> frz_col[c / MP_DIM]) else $error("column enabled without frozen tile"); // R4
  end
endmodule

bind pxr_readout pxr_readout_chk #(
  .ROWS(ROWS), .COLS(COLS), .MP_DIM(MP_DIM), .TS_W(TS_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mp_freeze(mp_freeze),
  .col_en   (col_en),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data)
);

// File: tb/sim_pxr_readout.sv
`timescale 1ns/1ps
module sim_pxr_readout;
  localparam int ROWS = 32, COLS = 128, MPD = 4, TSW = 8;
  localparam int MPR = ROWS / MPD, MPC = COLS / MPD, NMP = MPR * MPC;

  logic clk = 1'b0, rst_n = 1'b0, ts_tick = 1'b0, out_ready = 1'b0;
  logic [NMP-1:0]  mp_hit, mp_freeze, prev_frz;
  logic [COLS-1:0] col_en;
  logic [ROWS-1:0] row_data;
  logic            out_valid;
  logic [19:0]     out_data;
  logic [ROWS-1:0] pix [COLS];
  logic [19:0]     expq [$];
  int n_chk = 0, n_fail = 0, ts_cnt = 0, rdy_pct = 100;
  string cur_tag = "R8";

  always #2 clk = ~clk;

  pxr_readout u0 (
    .clk(clk), .rst_n(rst_n), .ts_tick(ts_tick), .mp_hit(mp_hit),
    .mp_freeze(mp_freeze), .col_en(col_en), .row_data(row_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  // Matrix model: tile flags and shared row lines.
  always_comb begin
    mp_hit = '0;
    for (int mr = 0; mr < MPR; mr++)
      for (int mc = 0; mc < MPC; mc++)
        for (int k = 0; k < MPD; k++)
          mp_hit[mr*MPC+mc] = mp_hit[mr*MPC+mc] | (|pix[mc*MPD+k][mr*MPD +: MPD]);
  end

  always_comb begin
    row_data = '0;
    for (int c = 0; c < COLS; c++) if (col_en[c]) row_data = row_data | pix[c];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // Stream sink, word compare and pixel reset on freeze release.
  always @(negedge clk) begin
    logic [19:0] e;
    out_ready = ($urandom_range(0, 99) < rdy_pct);
    if (out_valid && out_ready) begin
      if (expq.size() == 0) chk(1'b0, "R8 unexpected word", {12'h0, out_data}, 32'hFFFFFFFF);
      else begin
        e = expq.pop_front();
        chk(out_data == e, cur_tag, {12'h0, out_data}, {12'h0, e});
      end
    end
    for (int i = 0; i < NMP; i++) begin
      if (prev_frz[i] && !mp_freeze[i])
        for (int k = 0; k < MPD; k++) pix[(i % MPC)*MPD + k][(i / MPC)*MPD +: MPD] = '0;
    end
    prev_frz = mp_freeze;
  end

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); ts_tick = 1'b1;
      @(negedge clk); ts_tick = 1'b0; ts_cnt++;
    end
  endtask

  task automatic push_all();
    for (int c = 0; c < COLS; c++)
      for (int r = 0; r < ROWS; r++)
        if (pix[c][r]) expq.push_back({7'(c), 5'(r), 8'(ts_cnt)});
  endtask

  task automatic fill_random(input int pct, input int c_lo, input int c_hi);
    @(negedge clk);
    for (int c = c_lo; c <= c_hi; c++)
      for (int r = 0; r < ROWS; r++) pix[c][r] = ($urandom_range(0, 99) < pct);
    push_all();
  endtask

  task automatic wait_done(input string req);
    int n;
    n = 0;
    do begin @(negedge clk); n++; end
    while ((expq.size() != 0 || mp_freeze != '0) && n < 30000);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, req, expq.size(), 0);
    chk(mp_freeze == '0, "R3 release", $countones(mp_freeze), 0);
    chk(!out_valid && col_en == '0, "R2 back to idle", {31'h0, out_valid}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int bad;
    for (int c = 0; c < COLS; c++) pix[c] = '0;
    prev_frz = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mp_freeze == '0 && col_en == '0 && !out_valid, "R1 in reset", {31'h0, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mp_freeze == '0 && col_en == '0 && !out_valid, "R1 after reset", $countones(mp_freeze), 0);

    // R2: no flags, nothing moves
    bad = 0;
    repeat (20) begin @(negedge clk); if (col_en != '0 || out_valid) bad++; end
    chk(bad == 0, "R2 idle", bad, 0);

    // R6: single pixel, row 5 column 9, stamp 3
    cur_tag = "R6 single word";
    ticks(3);
    @(negedge clk); pix[9][5] = 1'b1; push_all();
    wait_done("R6 count");

    // R5: corner pixels
    cur_tag = "R5 corner order";
    @(negedge clk);
    pix[0][0] = 1'b1; pix[0][31] = 1'b1; pix[127][0] = 1'b1; pix[127][31] = 1'b1;
    push_all();
    wait_done("R5 count");

    // R10: full occupancy under stalls
    cur_tag = "R10 full matrix";
    rdy_pct = 50;
    fill_random(100, 0, COLS - 1);
    @(negedge clk);
    chk(&mp_freeze, "R3 all frozen", $countones(mp_freeze), NMP);
    wait_done("R10 count");

    // R5 / R8: random fills at several densities and stall rates
    for (int p = 0; p < 4; p++) begin
      cur_tag = "R8 random stream";
      rdy_pct = (p == 0) ? 100 : (p == 1) ? 30 : (p == 2) ? 70 : 15;
      ticks(1);
      fill_random((p == 0) ? 5 : (p == 1) ? 30 : (p == 2) ? 70 : 95, 0, COLS - 1);
      wait_done("R5 random count");
    end

    // R7: stamp wraps past 255
    cur_tag = "R7 wrapped stamp";
    rdy_pct = 60;
    ticks(260);
    fill_random(20, 0, COLS - 1);
    wait_done("R7 count");

    // R9 / R4: late hit in a column that shares a frozen tile column
    cur_tag = "R9 late hit";
    rdy_pct = 50;
    @(negedge clk);
    for (int c = 0; c < 16; c++)
      for (int r = 0; r < ROWS; r++) pix[c][r] = ($urandom_range(0, 99) < 60);
    pix[20][1] = 1'b1;
    push_all();
    bad = 0;
    while (!out_valid && bad < 100) begin @(negedge clk); bad++; end
    ticks(5);
    @(negedge clk);
    pix[21][14] = 1'b1;
    expq.push_back({7'd21, 5'd14, 8'(ts_cnt)});
    wait_done("R4 masked row count");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule